// File: doc/BRIEF.md
# Edge-Event GPIO Port

A general-purpose I/O peripheral with a parameterised number of pins (32 by default). It sits on a plain memory-mapped bus with an address, a write strobe, write data and read data. A direction register sets each pin as an input or an output. Output pins are driven from an output latch. Input pins pass through a two-flop synchroniser before any other logic uses them.

The synchronised inputs feed an edge detector. Each rising or falling transition on an input pin sets a sticky event bit. Software clears these bits by writing ones to them. An interrupt-enable mask selects which pins may raise the single interrupt request line. A pin with any pending event, rising or falling, raises the request if its enable bit is set.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the port is in a fixed state. Every direction bit reads 1, so every pin is an input. The interrupt-enable register reads 0. Both event registers read 0. The `irq` output is 0 and `pin_out` is 0.
- R2: Registers sit at byte offsets 0x00 (direction), 0x04 (interrupt enable), 0x08 (rising events), 0x0C (falling events) and 0x10 (pin value). A write to direction or enable reads back unchanged. `bus_rdata` is registered: it shows the register addressed in the previous cycle.
- R3: Direction bit value 0 makes the pin an output and 1 makes it an input. The `pin_dir` output mirrors the direction register.
- R4: A write to the value offset updates the output latch only in bits whose pin is an output. Latch bits for input pins keep their old value. `pin_out` presents the latch.
- R5: A read of the value offset returns the latch bit for each output pin. For each input pin it returns the synchronised input level, which lags `pin_in` by two clocks.
- R6: When an input pin goes from 0 to 1, its bit in the rising-event register is set. The bit stays set until it is cleared.
- R7: When an input pin goes from 1 to 0, its bit in the falling-event register is set. The bit stays set until it is cleared.
- R8: Transitions on output-configured pins set no event bit.
- R9: Writing 1 to a bit of an event register clears that bit. Writing 0 to a bit leaves it unchanged.
- R10: If a new edge and a clear hit the same event bit in the same cycle, the bit stays set.
- R11: `irq` is the registered OR over all pins of (enable AND (rising event OR falling event)). It follows the event and enable registers with one clock of delay.
- R12: Some accesses are treated as unmapped: any offset above 0x10, and any offset whose two low address bits are not 00. Reads of these offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Registered read data |
| pin_in | input | NPINS (32) | Asynchronous pad inputs |
| pin_out | output | NPINS (32) | Output latch driven to the pads |
| pin_dir | output | NPINS (32) | Per-pin direction, 1 = input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs.
- `rst` is high from time zero, so the first sampled cycles fall under reset.
- Bus signals are stable at each rising clock edge.
- `pin_in` is low while reset is released. Otherwise a high pin at release looks like a fresh rising edge, because the synchroniser clears to 0.

The stimulus keeps within these assumptions in three ways. It changes pins and bus signals only on falling clock edges. It holds every pin at 0 through reset. It issues at most one bus access per cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_COUNT = 5;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_IEN  = 3'd1,
    SEL_RISE = 3'd2,
    SEL_FALL = 3'd3,
    SEL_VAL  = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [1:0] low, input int unsigned word);
    reg_sel_e s;
    if (low != 2'b00 || word >= REG_COUNT) s = SEL_NONE;
    else                                  s = reg_sel_e'(word[2:0]);
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] level_prev
);
  logic [NPINS-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_prev <= '0;
    else     level_prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt_reg.sv
module gpio_evt_reg #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] evt_q
);
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (evt_q & ~clr) | hit;
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_ien,
  input  logic             wr_val,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] ien_q,
  output logic [NPINS-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      ien_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_ien) ien_q <= wdata;
      if (wr_val) out_q <= (out_q & dir_q) | (wdata & ~dir_q);
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_dir,
  output logic              irq
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  reg_sel_e         sel;
  logic [NPINS-1:0] dir_q, ien_q, out_q;
  logic [NPINS-1:0] lvl, lvl_prev;
  logic [NPINS-1:0] rise_hit, fall_hit;
  logic [NPINS-1:0] rise_q, fall_q;
  logic [NPINS-1:0] rise_clr, fall_clr;
  logic [NPINS-1:0] val_view;
  logic [WORD_W-1:0] word_idx;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign sel      = decode_sel(bus_addr[1:0], int'(word_idx));

  gpio_cfg_regs #(.NPINS(NPINS)) cfg_i (
    .clk   (clk),
    .rst   (rst),
    .wr_dir(bus_we && sel == SEL_DIR),
    .wr_ien(bus_we && sel == SEL_IEN),
    .wr_val(bus_we && sel == SEL_VAL),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .ien_q (ien_q),
    .out_q (out_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (pin_in),
    .level     (lvl),
    .level_prev(lvl_prev)
  );

  assign rise_hit = lvl & ~lvl_prev & dir_q;
  assign fall_hit = ~lvl & lvl_prev & dir_q;
  assign rise_clr = (bus_we && sel == SEL_RISE) ? bus_wdata : '0;
  assign fall_clr = (bus_we && sel == SEL_FALL) ? bus_wdata : '0;

  gpio_evt_reg #(.NPINS(NPINS)) rise_i (
    .clk(clk), .rst(rst), .hit(rise_hit), .clr(rise_clr), .evt_q(rise_q)
  );

  gpio_evt_reg #(.NPINS(NPINS)) fall_i (
    .clk(clk), .rst(rst), .hit(fall_hit), .clr(fall_clr), .evt_q(fall_q)
  );

  assign val_view = (lvl & dir_q) | (out_q & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(ien_q & (rise_q | fall_q));
      unique case (sel)
        SEL_DIR:  bus_rdata <= dir_q;
        SEL_IEN:  bus_rdata <= ien_q;
        SEL_RISE: bus_rdata <= rise_q;
        SEL_FALL: bus_rdata <= fall_q;
        SEL_VAL:  bus_rdata <= val_view;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_dir = dir_q;
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic              irq,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  rise_q,
  input logic [NPINS-1:0]  fall_q
);
  logic             unmapped;
  logic [NPINS-1:0] clr_r, clr_f;

  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr > ADDR_W'(16));
  assign clr_r = (bus_we && bus_addr == ADDR_W'(8))  ? bus_wdata : '0;
  assign clr_f = (bus_we && bus_addr == ADDR_W'(12)) ? bus_wdata : '0;

  // R1
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '1 && ien_q == '0 && rise_q == '0 && fall_q == '0 && !irq));

  // R6 / R9
  a_r6_rise_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(rise_q) & ~$past(clr_r)) & ~rise_q) == '0);

  // R7 / R9
  a_r7_fall_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(fall_q) & ~$past(clr_f)) & ~fall_q) == '0);

  // R8
  a_r8_no_event_on_outputs: assert property (@(posedge clk) disable iff (rst)
    ((((rise_q & ~$past(rise_q)) | (fall_q & ~$past(fall_q))) & ~$past(dir_q)) == '0));

  // R4
  a_r4_inputs_hold_latch: assert property (@(posedge clk) disable iff (rst)
    ((pin_out ^ $past(pin_out)) & $past(dir_q)) == '0);

  // R11
  a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == |($past(ien_q) & ($past(rise_q) | $past(fall_q))));

  // R12
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(unmapped) |-> bus_rdata == '0);
endmodule

bind gpio_edge_port gpio_edge_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .irq      (irq),
  .dir_q    (dir_q),
  .ien_q    (ien_q),
  .rise_q   (rise_q),
  .fall_q   (fall_q)
);

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N  = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_dir;
  logic          irq;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } exp_item_t;

  exp_item_t q[$];
  logic      rd_vld = 1'b0;
  int        n_chk = 0;
  int        n_bad = 0;
  bit        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port #(.NPINS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .irq(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the registered result appears
  always @(posedge clk) begin
    if (rd_vld) begin
      #1;
      if (q.size() == 0) check("scoreboard underflow", 0, 1);
      else begin
        exp_item_t it;
        it = q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [N-1:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    q.push_back(it);
    bus_addr = a; bus_we = 1'b0; rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check("watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pin_dir", pin_dir, '1);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", N'(irq), '0);
    rd(8'h00, 32'hFFFF_FFFF, "R1 dir");
    rd(8'h04, 32'h0, "R1 ien");
    rd(8'h08, 32'h0, "R1 rise");
    rd(8'h0C, 32'h0, "R1 fall");

    // R2 readback
    wr(8'h04, 32'h0000_00F0);
    rd(8'h04, 32'h0000_00F0, "R2 ien readback");
    wr(8'h00, 32'hFFFF_0000);
    rd(8'h00, 32'hFFFF_0000, "R2 dir readback");
    check("R3 pin_dir", pin_dir, 32'hFFFF_0000);

    // R4 only output bits take the write
    wr(8'h10, 32'hA5A5_A5A5);
    check("R4 pin_out", pin_out, 32'h0000_A5A5);
    rd(8'h10, 32'h0000_A5A5, "R5 value outputs");

    // R5/R6/R8 input edges
    @(negedge clk); pin_in = 32'h1234_FFFF;
    idle(4);
    rd(8'h10, 32'h1234_A5A5, "R5 value mixed");
    rd(8'h08, 32'h1234_0000, "R6 rise set / R8 outputs ignored");
    rd(8'h0C, 32'h0, "R8 no fall");
    check("R11 irq masked", N'(irq), '0);

    wr(8'h04, 32'h0004_0000);
    idle(1);
    check("R11 irq enabled", N'(irq), 1);

    // R9 clear
    wr(8'h08, 32'h0004_0000);
    idle(1);
    rd(8'h08, 32'h1230_0000, "R9 clear one");
    check("R11 irq dropped", N'(irq), '0);
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h1230_0000, "R9 zero write keeps");

    // R7 falling
    @(negedge clk); pin_in = 32'h1000_0000;
    idle(4);
    rd(8'h0C, 32'h0234_0000, "R7 fall set");
    rd(8'h08, 32'h1230_0000, "R6 rise sticky");

    // R10 collision: edge on bit 22 lands the same cycle as clear
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R9 fall cleared");
    @(negedge clk); pin_in = 32'h1040_0000;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h1040_0000; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(8'h08, 32'h0270_0000, "R10 set wins over clear");

    // R12 unmapped
    rd(8'h14, 32'h0, "R12 unmapped read");
    rd(8'h01, 32'h0, "R12 misaligned read");
    wr(8'h14, 32'h0);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_0000, "R12 dir untouched");
    rd(8'h04, 32'h0004_0000, "R12 ien untouched");

    // R3 back to all inputs
    wr(8'h00, 32'hFFFF_FFFF);
    check("R3 all inputs", pin_dir, '1);
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule